// File: doc/BRIEF.md
# Timesync Counter with One-Shot Compare Output

This block keeps a 64-bit nanosecond time counter that advances by a fixed step on every clock. Software reaches it through a small 32-bit register bus. It can halt the counter, load either 32-bit half, and let it run again. A single compare channel holds a 63-bit target and an arm flag. When the running counter equals the target, the channel fires once and disarms itself.

A two-bit source field in the control register decides whether the compare event reaches the timesync GPIO pin. When the compare channel is selected, every firing flips the pin level. Any other source code holds the pin low and freezes its level. The halt and run bits in the same register are commands, not stored state. Every control write also stores the source field, so software must read the register, change only the command bits, and write the result back.

Top module: `tsync_timer`

## Requirements
- R1: After reset the counter is 0 and running, the compare channel is disarmed with a zero target, the source field is 0 and `gpio_o` is low. A read of the control register then returns 0x0000_0001.
- R2: While running and not loaded, the counter grows by `INC_NS` on each clock, with carries from the low half into the high half. Offset 0x690C reads bits 31:0 and offset 0x6910 reads bits 63:32.
- R3: A control write (offset 0x6908) with bit 1 set halts the counter, and it then holds its value. A control write with bit 2 set restarts it. When both bits are set, the halt takes priority.
- R4: A write to 0x690C replaces counter bits 31:0, and a write to 0x6910 replaces bits 63:32. In that cycle the load takes the place of the increment, whether the counter is running or halted.
- R5: A control read returns the source field in bits 17:16 and the running flag in bit 0. All other bits, including 1 and 2, read as 0. Every control write stores data bits 17:16 into the source field.
- R6: The compare target low word is at 0x6918. At 0x691C, bit 31 is the arm flag and bits 30:0 are the target bits 62:32. Both words read back as written, and the arm flag reads its live value.
- R7: At a clock edge where the channel is armed, the counter is running and counter bits 62:0 equal the target, the channel fires and the arm flag clears. Counter bit 63 is not compared, and the channel fires only once per arming.
- R8: A halted counter never causes a firing, even when it equals the armed target. The first running cycle at that value does fire.
- R9: When the source field is 2'b10, each firing flips the level of `gpio_o`. For any other source code, `gpio_o` is low and a firing leaves the stored level unchanged. Selecting 2'b10 again brings that stored level back out.
- R10: Writing 0 to 0x691C disarms the channel, and the counter then passes the old target without a firing.
- R11: A read from any other address returns 0, and a write to any other address changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Register byte address |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| gpio_o | output | 1 | Timesync GPIO output |

## Verification
The hardest case to reach is an exact equality between the counter and the target. The counter moves in steps of `INC_NS`, so a target that is not a multiple of the step away from the counter is never hit. The bench reaches equality on purpose. It halts the counter, loads a known value, writes a target a whole number of steps ahead and then restarts the counter, so the firing lands in a cycle it can predict. The same halt-and-load method sets up the cases where the counter already equals the target while halted, and where counter bit 63 differs from the target.

// File: rtl/tsync_pkg.sv
package tsync_pkg;

  localparam int HALF_W = 32;
  localparam int CNT_W  = 2 * HALF_W;
  localparam int TGT_W  = CNT_W - 1;

  localparam logic [15:0] OFS_CTRL   = 16'h6908;
  localparam logic [15:0] OFS_CNT_LO = 16'h690C;
  localparam logic [15:0] OFS_CNT_HI = 16'h6910;
  localparam logic [15:0] OFS_CMP_LO = 16'h6918;
  localparam logic [15:0] OFS_CMP_HI = 16'h691C;

  localparam int CTL_RUN_BIT  = 0;
  localparam int CTL_HALT_BIT = 1;
  localparam int CTL_GO_BIT   = 2;
  localparam int CTL_SRC_LSB  = 16;
  localparam int CMP_ARM_BIT  = HALF_W - 1;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_RSV1 = 2'b01,
    SRC_CMP0 = 2'b10,
    SRC_RSV3 = 2'b11
  } gpio_src_e;

  function automatic logic [CNT_W-1:0] cnt_advance(input logic [CNT_W-1:0] cur,
                                                   input logic [CNT_W-1:0] step);
    return cur + step;
  endfunction

  function automatic logic cmp_hit(input logic [TGT_W-1:0] cur,
                                   input logic [TGT_W-1:0] tgt);
    return cur == tgt;
  endfunction

endpackage

// File: rtl/tsync_counter.sv
module tsync_counter
  import tsync_pkg::*;
#(
  parameter int INC_NS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_i,
  input  logic              go_i,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic [HALF_W-1:0] ld_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              running_o,
  output logic              step_o
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(INC_NS);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  // Named event: the counter takes an increment at the coming edge
  assign step_o = run_q && !ld_lo_i && !ld_hi_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else begin
      if (halt_i)
        run_q <= 1'b0;
      else if (go_i)
        run_q <= 1'b1;

      if (ld_lo_i)
        cnt_q[HALF_W-1:0] <= ld_data_i;
      else if (ld_hi_i)
        cnt_q[CNT_W-1:HALF_W] <= ld_data_i;
      else if (step_o)
        cnt_q <= cnt_advance(cnt_q, STEP);
    end
  end

  assign count_o   = cnt_q;
  assign running_o = run_q;

endmodule

// File: rtl/tsync_compare.sv
module tsync_compare
  import tsync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic [TGT_W-1:0]  count_i,
  input  logic              running_i,
  output logic [TGT_W-1:0]  target_o,
  output logic              armed_o,
  output logic              fire_o
);

  logic [HALF_W-1:0] tgt_lo_q;
  logic [HALF_W-2:0] tgt_hi_q;
  logic              arm_q;
  logic [TGT_W-1:0]  target;

  assign target = {tgt_hi_q, tgt_lo_q};

  // Named event: one-shot firing at the coming edge
  assign fire_o = arm_q && running_i && cmp_hit(count_i, target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_lo_q <= '0;
      tgt_hi_q <= '0;
      arm_q    <= 1'b0;
    end else begin
      if (wr_lo_i)
        tgt_lo_q <= wdata_i;
      if (wr_hi_i) begin
        tgt_hi_q <= wdata_i[HALF_W-2:0];
        arm_q    <= wdata_i[CMP_ARM_BIT];
      end else if (fire_o) begin
        arm_q    <= 1'b0;
      end
    end
  end

  assign target_o = target;
  assign armed_o  = arm_q;

endmodule

// File: rtl/tsync_gpio.sv
module tsync_gpio
  import tsync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl_i,
  input  logic [1:0] src_wr_i,
  input  logic       fire_i,
  output logic [1:0] src_o,
  output logic       gpio_o
);

  gpio_src_e src_q;
  logic      lvl_q;
  logic      routed;

  assign routed = (src_q == SRC_CMP0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_NONE;
      lvl_q <= 1'b0;
    end else begin
      if (fire_i && routed)
        lvl_q <= ~lvl_q;
      if (wr_ctrl_i)
        src_q <= gpio_src_e'(src_wr_i);
    end
  end

  assign src_o  = src_q;
  assign gpio_o = routed & lvl_q;

endmodule

// File: rtl/tsync_timer.sv
module tsync_timer
  import tsync_pkg::*;
#(
  parameter int INC_NS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       addr_i,
  input  logic              wr_en_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o,
  output logic              gpio_o
);

  logic             wr_ctrl, wr_cnt_lo, wr_cnt_hi, wr_cmp_lo, wr_cmp_hi;
  logic [CNT_W-1:0] count;
  logic             running;
  logic             cnt_step;
  logic [TGT_W-1:0] target;
  logic             armed;
  logic             cmp_fire;
  logic [1:0]       src;

  assign wr_ctrl   = wr_en_i && (addr_i == OFS_CTRL);
  assign wr_cnt_lo = wr_en_i && (addr_i == OFS_CNT_LO);
  assign wr_cnt_hi = wr_en_i && (addr_i == OFS_CNT_HI);
  assign wr_cmp_lo = wr_en_i && (addr_i == OFS_CMP_LO);
  assign wr_cmp_hi = wr_en_i && (addr_i == OFS_CMP_HI);

  tsync_counter #(.INC_NS(INC_NS)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_i    (wr_ctrl && wdata_i[CTL_HALT_BIT]),
    .go_i      (wr_ctrl && wdata_i[CTL_GO_BIT]),
    .ld_lo_i   (wr_cnt_lo),
    .ld_hi_i   (wr_cnt_hi),
    .ld_data_i (wdata_i),
    .count_o   (count),
    .running_o (running),
    .step_o    (cnt_step)
  );

  tsync_compare u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_lo_i   (wr_cmp_lo),
    .wr_hi_i   (wr_cmp_hi),
    .wdata_i   (wdata_i),
    .count_i   (count[TGT_W-1:0]),
    .running_i (running),
    .target_o  (target),
    .armed_o   (armed),
    .fire_o    (cmp_fire)
  );

  tsync_gpio u_gpio (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl_i (wr_ctrl),
    .src_wr_i  (wdata_i[CTL_SRC_LSB+1:CTL_SRC_LSB]),
    .fire_i    (cmp_fire),
    .src_o     (src),
    .gpio_o    (gpio_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL: begin
        rdata_o[CTL_SRC_LSB+1:CTL_SRC_LSB] = src;
        rdata_o[CTL_RUN_BIT]               = running;
      end
      OFS_CNT_LO: rdata_o = count[HALF_W-1:0];
      OFS_CNT_HI: rdata_o = count[CNT_W-1:HALF_W];
      OFS_CMP_LO: rdata_o = target[HALF_W-1:0];
      OFS_CMP_HI: rdata_o = {armed, target[TGT_W-1:HALF_W]};
      default:    rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/tsync_checker.sv
module tsync_checker
  import tsync_pkg::*;
#(
  parameter int INC_NS = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       addr,
  input logic              wr_en,
  input logic [HALF_W-1:0] rdata,
  input logic [CNT_W-1:0]  count,
  input logic              running,
  input logic              step,
  input logic              armed,
  input logic              fire,
  input logic [1:0]        src,
  input logic              gpio
);

  logic loading;
  assign loading = wr_en && (addr == OFS_CNT_LO || addr == OFS_CNT_HI);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (count == $past(count) + CNT_W'(INC_NS)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !loading) |=> $stable(count));

  assert_cmd_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_CTRL) |-> (rdata[CTL_GO_BIT:CTL_HALT_BIT] == 2'b00));

  assert_arm_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(wr_en && addr == OFS_CMP_HI));

  assert_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !(wr_en && addr == OFS_CMP_HI)) |=> !armed);

  assert_gpio_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio != $past(gpio)) |-> ($past(fire) || (src != $past(src))));

endmodule

bind tsync_timer tsync_checker #(.INC_NS(INC_NS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr_i),
  .wr_en   (wr_en_i),
  .rdata   (rdata_o),
  .count   (count),
  .running (running),
  .step    (cnt_step),
  .armed   (armed),
  .fire    (cmp_fire),
  .src     (src),
  .gpio    (gpio_o)
);

// File: tb/sim_tsync_timer.sv
module sim_tsync_timer;

  localparam int STEP_NS = 10;
  localparam logic [15:0] A_CTL = 16'h6908, A_TLO = 16'h690C, A_THI = 16'h6910,
                          A_MLO = 16'h6918, A_MHI = 16'h691C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0;
  logic        we = 1'b0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        gpio;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // reference state
  logic [63:0] m_cnt;
  logic        m_run;
  logic [62:0] m_tgt;
  logic        m_arm;
  logic [1:0]  m_src;
  logic        m_lvl;

  always #5 clk = ~clk;

  tsync_timer #(.INC_NS(STEP_NS)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .gpio_o(gpio)
  );

  function automatic logic [31:0] m_read(input logic [15:0] a);
    logic [31:0] r = 32'h0;
    case (a)
      A_CTL: begin r[17:16] = m_src; r[0] = m_run; end
      A_TLO: r = m_cnt[31:0];
      A_THI: r = m_cnt[63:32];
      A_MLO: r = m_tgt[31:0];
      A_MHI: r = {m_arm, m_tgt[62:32]};
      default: r = 32'h0;
    endcase
    return r;
  endfunction

  function automatic logic m_gpio();
    return (m_src == 2'b10) ? m_lvl : 1'b0;
  endfunction

  task automatic m_clock(input logic [15:0] a, input logic w, input logic [31:0] d);
    bit hit;
    hit = m_arm && m_run && (m_cnt[62:0] == m_tgt);
    if (hit && m_src == 2'b10) m_lvl = !m_lvl;
    if (w && a == A_TLO)      m_cnt[31:0] = d;
    else if (w && a == A_THI) m_cnt[63:32] = d;
    else if (m_run)           m_cnt = m_cnt + 64'(STEP_NS);
    if (w && a == A_MLO) m_tgt[31:0] = d;
    if (w && a == A_MHI) begin m_tgt[62:32] = d[30:0]; m_arm = d[31]; end
    else if (hit) m_arm = 1'b0;
    if (w && a == A_CTL) begin
      if (d[1]) m_run = 1'b0;
      else if (d[2]) m_run = 1'b1;
      m_src = d[17:16];
    end
  endtask

  task automatic step(input logic [15:0] a, input logic w, input logic [31:0] d, input string tag);
    logic [31:0] er;
    logic        eg;
    addr = a; we = w; wdata = d;
    #2;
    er = m_read(a);
    eg = m_gpio();
    checks++;
    if (rdata !== er || gpio !== eg) begin
      fails++;
      $display("FAIL %s addr=%h rdata=%h exp=%h gpio=%b exp=%b", tag, a, rdata, er, gpio, eg);
    end
    @(posedge clk);
    m_clock(a, w, d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input logic [15:0] a, input int n, input string tag);
    for (int i = 0; i < n; i++) step(a, 1'b0, 32'h0, tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_cnt = '0; m_run = 1'b1; m_tgt = '0; m_arm = 1'b0; m_src = 2'b00; m_lvl = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step(A_CTL, 0, 0, "R1");
    step(A_MHI, 0, 0, "R1");
    step(A_MLO, 0, 0, "R1");
    // R2 free running
    idle(A_TLO, 4, "R2");
    step(A_THI, 0, 0, "R2");
    // R3 halt, both bits, restart
    step(A_CTL, 1, 32'h2, "R3");
    idle(A_TLO, 3, "R3");
    step(A_CTL, 1, 32'h4, "R3");
    idle(A_TLO, 2, "R3");
    step(A_CTL, 1, 32'h6, "R3");
    idle(A_CTL, 2, "R3");
    step(A_CTL, 1, 32'h4, "R3");
    // R4 loads, carry across halves (R2)
    step(A_CTL, 1, 32'h2, "R4");
    step(A_TLO, 1, 32'hFFFF_FFE2, "R4");
    step(A_THI, 1, 32'h0000_0001, "R4");
    step(A_THI, 0, 0, "R4");
    step(A_CTL, 1, 32'h4, "R4");
    idle(A_TLO, 4, "R2");
    step(A_THI, 0, 0, "R2");
    step(A_TLO, 1, 32'h0000_1000, "R4");
    idle(A_TLO, 2, "R4");
    // R5 source field and command readback
    step(A_CTL, 1, 32'h0002_0004, "R5");
    step(A_CTL, 0, 0, "R5");
    step(A_CTL, 1, 32'hFFFC_FFFA, "R5");
    step(A_CTL, 0, 0, "R5");
    step(A_CTL, 1, 32'h0002_0004, "R5");
    step(A_CTL, 0, 0, "R5");
    // R6/R7 armed event
    step(A_CTL, 1, 32'h0002_0002, "R7");
    step(A_TLO, 1, 32'd1000, "R7");
    step(A_THI, 1, 32'h0, "R7");
    step(A_MLO, 1, 32'd1050, "R6");
    step(A_MHI, 1, 32'h8000_0000, "R6");
    step(A_MHI, 0, 0, "R6");
    step(A_MLO, 0, 0, "R6");
    step(A_CTL, 1, 32'h0002_0004, "R7");
    idle(A_MHI, 10, "R7");
    // R7 counter bit 63 ignored
    step(A_CTL, 1, 32'h0002_0002, "R7");
    step(A_TLO, 1, 32'h0, "R7");
    step(A_THI, 1, 32'h8000_0000, "R7");
    step(A_MLO, 1, 32'd100, "R7");
    step(A_MHI, 1, 32'h8000_0000, "R7");
    step(A_CTL, 1, 32'h0002_0004, "R7");
    idle(A_MHI, 14, "R7");
    // R8 halted at target: no firing until running
    step(A_CTL, 1, 32'h0002_0002, "R8");
    step(A_THI, 1, 32'h0, "R8");
    step(A_TLO, 1, 32'd500, "R8");
    step(A_MLO, 1, 32'd500, "R8");
    step(A_MHI, 1, 32'h8000_0000, "R8");
    idle(A_MHI, 5, "R8");
    step(A_CTL, 1, 32'h0002_0004, "R8");
    idle(A_MHI, 3, "R8");
    // R10 disarm
    step(A_CTL, 1, 32'h0002_0002, "R10");
    step(A_TLO, 1, 32'h0, "R10");
    step(A_MLO, 1, 32'd50, "R10");
    step(A_MHI, 1, 32'h8000_0000, "R10");
    step(A_MHI, 1, 32'h0, "R10");
    step(A_CTL, 1, 32'h0002_0004, "R10");
    idle(A_MHI, 10, "R10");
    // R9 other source codes hold the pin low and freeze the level
    step(A_CTL, 1, 32'h0001_0002, "R9");
    step(A_TLO, 1, 32'h0, "R9");
    step(A_MLO, 1, 32'd30, "R9");
    step(A_MHI, 1, 32'h8000_0000, "R9");
    step(A_CTL, 1, 32'h0001_0004, "R9");
    idle(A_MHI, 6, "R9");
    step(A_CTL, 1, 32'h0000_0000, "R9");
    step(A_CTL, 1, 32'h0003_0000, "R9");
    step(A_CTL, 1, 32'h0002_0000, "R9");
    idle(A_CTL, 2, "R9");
    // R11 unmapped addresses
    step(16'h6914, 1, 32'hFFFF_FFFF, "R11");
    step(16'h6914, 0, 0, "R11");
    step(16'h6900, 1, 32'hFFFF_FFFF, "R11");
    step(16'h0000, 0, 0, "R11");
    step(A_CTL, 0, 0, "R11");
    step(A_MLO, 0, 0, "R11");
    step(A_MHI, 0, 0, "R11");
    step(A_THI, 0, 0, "R11");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule